// File: doc/BRIEF.md
# Page Map Entry Controller

This block keeps a small table of page translation entries for a virtual-memory storage path. Each entry carries a 16-bit real page number and three flags: write-protect, dirty and referenced. When a storage reference arrives, the controller reads the indexed entry and decides whether the reference faults. If it does not fault, the controller updates the flags. In every case it reports the entry as it was before the reference.

Software changes an entry through a buffered map-write command. The command is captured into a holding register, a busy flag rises, and the table is written a fixed number of cycles later. The command is never stalled. A read-only form of the command goes through the same steps but leaves the entry untouched, so it can be used purely to observe an entry. Page-number parity is stored with every entry. The dirty flag is kept in two copies so that setting it never disturbs the parity.

Top module: `page_map_ctrl`

## Requirements
- R1: After synchronous reset every entry reads as Vacant (page 0, WP=1, Dirty=1, Ref=0), and `mw_busy`, `mw_proto_err` and `rsp_valid` are 0.
- R2: A lookup presented on `lk_valid` produces `rsp_valid`=1 and `rsp_is_map`=0 one cycle later, carrying the entry's page number and flags as they stood before this lookup.
- R3: A lookup to a Vacant entry (WP and Dirty both 1) sets `rsp_vacant` and `fault_wake`, and leaves the entry unchanged, including Ref.
- R4: Lookup kinds are 0 = read, 1 = write miss, 2 = dirty store (io store or victim write), 3 = treated as read. A kind 1 or 2 lookup to a non-vacant entry with WP=1 sets `rsp_wp_fault` and `fault_wake` and leaves the entry unchanged. A kind 0 lookup to the same entry does not fault.
- R5: A lookup that does not fault sets Ref. Only kind 2 also sets Dirty; kinds 0 and 1 leave Dirty as it was.
- R6: A map write accepted while idle raises `mw_busy` one cycle later. When no lookup intervenes, the table is written, `mw_busy` falls, and a response with `rsp_is_map`=1 carrying the old entry appears 9 cycles after acceptance. The new entry has Ref=0.
- R7: A map write with `mw_readonly`=1 follows the same timing and returns the old entry, but does not modify the entry.
- R8: A map-write response never asserts `fault_wake`. A Vacant previous entry is shown only on `rsp_vacant`.
- R9: A map write presented while `mw_busy` is 1 is dropped and sets the sticky `mw_proto_err`. The buffered write commits its original data.
- R10: A buffered write does not commit in a cycle that carries a lookup. It waits for the first cycle free of lookups, and `mw_busy` stays 1 until then.
- R11: Parity is odd over page number and WP, with both Dirty copies included and Ref excluded. `rsp_par_err` stays 0 for every entry written through the ports, including after Dirty has been set by a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Storage reference lookup strobe |
| lk_idx | input | 6 | Entry index of the lookup |
| lk_kind | input | 2 | Reference kind (0 read, 1 write miss, 2 dirty store, 3 read) |
| mw_valid | input | 1 | Map-write command strobe |
| mw_idx | input | 6 | Entry index of the map write |
| mw_rpn | input | 16 | Real page number to write |
| mw_wp | input | 1 | Write-protect value to write |
| mw_dirty | input | 1 | Dirty value to write |
| mw_readonly | input | 1 | Return entry without modifying it |
| mw_busy | output | 1 | Buffered map write pending |
| mw_proto_err | output | 1 | Sticky: map write issued while busy |
| rsp_valid | output | 1 | Response valid |
| rsp_is_map | output | 1 | Response belongs to a map write |
| rsp_rpn | output | 16 | Previous real page number |
| rsp_wp | output | 1 | Previous WP |
| rsp_dirty | output | 1 | Previous Dirty |
| rsp_ref | output | 1 | Previous Ref |
| rsp_vacant | output | 1 | Previous entry was Vacant |
| rsp_par_err | output | 1 | Previous entry failed parity |
| rsp_wp_fault | output | 1 | Lookup hit a write-protect fault |
| fault_wake | output | 1 | Lookup fault needing service |

## Verification
A lookup answers on the cycle after the edge that samples it. The bench drives each lookup at a falling edge and reads the response at the next falling edge. A map write shows busy one edge after acceptance, stays busy through eight more edges, and answers on the ninth. The bench checks busy at each of those falling edges and reads the response exactly at the ninth. For the deferred commit, lookups are placed over the ninth and tenth edges, and the map response is expected two edges later than usual.

// File: rtl/page_map_pkg.sv
package page_map_pkg;

    localparam int RPN_W = 16;

    typedef enum logic [1:0] {
        REF_READ   = 2'd0,
        REF_WMISS  = 2'd1,
        REF_DSTORE = 2'd2,
        REF_SPARE  = 2'd3
    } ref_kind_e;

    typedef struct packed {
        logic [RPN_W-1:0] rpn;
        logic             wp;
        logic             dirty_a;
        logic             dirty_b;
        logic             refd;
        logic             par;
    } map_entry_t;

    function automatic logic make_par(input logic [RPN_W-1:0] rpn, input logic wp);
        return ~(^{rpn, wp});
    endfunction

    function automatic logic par_good(input map_entry_t e);
        return ^{e.rpn, e.wp, e.dirty_a, e.dirty_b, e.par};
    endfunction

    function automatic logic is_vacant(input map_entry_t e);
        return e.wp & e.dirty_a;
    endfunction

    function automatic map_entry_t vacant_entry();
        map_entry_t e;
        e.rpn     = '0;
        e.wp      = 1'b1;
        e.dirty_a = 1'b1;
        e.dirty_b = 1'b1;
        e.refd    = 1'b0;
        e.par     = make_par('0, 1'b1);
        return e;
    endfunction

endpackage

// File: rtl/page_map_table.sv
module page_map_table
    import page_map_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output map_entry_t       rd_entry,
    input  logic             wr_en,
    input  map_entry_t       wr_entry
);

    map_entry_t mem [ENTRIES];

    assign rd_entry = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= vacant_entry();
            end
        end else if (wr_en) begin
            mem[idx] <= wr_entry;
        end
    end

    // Every value stored through the write port must carry good parity
    assert_store_parity_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> par_good(wr_entry));

endmodule

// File: rtl/page_map_wbuf.sv
module page_map_wbuf
    import page_map_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int DELAY   = 9,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(DELAY)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mw_valid,
    input  logic [IDX_W-1:0] mw_idx,
    input  logic [RPN_W-1:0] mw_rpn,
    input  logic             mw_wp,
    input  logic             mw_dirty,
    input  logic             mw_readonly,
    input  logic             hold,
    output logic             busy,
    output logic             proto_err,
    output logic             commit,
    output logic [IDX_W-1:0] buf_idx,
    output logic [RPN_W-1:0] buf_rpn,
    output logic             buf_wp,
    output logic             buf_dirty,
    output logic             buf_ro
);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept = mw_valid && !busy;
    assign commit = busy && (cnt == '0) && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            proto_err <= 1'b0;
            cnt       <= '0;
            buf_idx   <= '0;
            buf_rpn   <= '0;
            buf_wp    <= 1'b0;
            buf_dirty <= 1'b0;
            buf_ro    <= 1'b0;
        end else begin
            if (accept) begin
                busy      <= 1'b1;
                cnt       <= CNT_W'(DELAY - 1);
                buf_idx   <= mw_idx;
                buf_rpn   <= mw_rpn;
                buf_wp    <= mw_wp;
                buf_dirty <= mw_dirty;
                buf_ro    <= mw_readonly;
            end else if (busy) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (!hold) begin
                    busy <= 1'b0;
                end
            end
            if (mw_valid && busy) begin
                proto_err <= 1'b1;
            end
        end
    end

    assert_busy_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !busy) |=> busy);

    assert_drop_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && busy) |=> (proto_err && $stable(buf_rpn) && $stable(buf_idx)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    assert_no_commit_under_lookup_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && hold) |=> busy);

endmodule

// File: rtl/page_map_ctrl.sv
module page_map_ctrl
    import page_map_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int DELAY   = 9,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [1:0]       lk_kind,
    input  logic             mw_valid,
    input  logic [IDX_W-1:0] mw_idx,
    input  logic [RPN_W-1:0] mw_rpn,
    input  logic             mw_wp,
    input  logic             mw_dirty,
    input  logic             mw_readonly,
    output logic             mw_busy,
    output logic             mw_proto_err,
    output logic             rsp_valid,
    output logic             rsp_is_map,
    output logic [RPN_W-1:0] rsp_rpn,
    output logic             rsp_wp,
    output logic             rsp_dirty,
    output logic             rsp_ref,
    output logic             rsp_vacant,
    output logic             rsp_par_err,
    output logic             rsp_wp_fault,
    output logic             fault_wake
);

    logic             commit;
    logic [IDX_W-1:0] buf_idx;
    logic [RPN_W-1:0] buf_rpn;
    logic             buf_wp;
    logic             buf_dirty;
    logic             buf_ro;

    page_map_wbuf #(.ENTRIES(ENTRIES), .DELAY(DELAY)) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .mw_valid   (mw_valid),
        .mw_idx     (mw_idx),
        .mw_rpn     (mw_rpn),
        .mw_wp      (mw_wp),
        .mw_dirty   (mw_dirty),
        .mw_readonly(mw_readonly),
        .hold       (lk_valid),
        .busy       (mw_busy),
        .proto_err  (mw_proto_err),
        .commit     (commit),
        .buf_idx    (buf_idx),
        .buf_rpn    (buf_rpn),
        .buf_wp     (buf_wp),
        .buf_dirty  (buf_dirty),
        .buf_ro     (buf_ro)
    );

    logic [IDX_W-1:0] sel_idx;
    map_entry_t       old_e;
    map_entry_t       upd_e;
    map_entry_t       new_e;
    map_entry_t       wr_e;
    logic             wr_en;
    ref_kind_e        kind;
    logic             is_write_kind;
    logic             vac;
    logic             bad_par;
    logic             wp_hit;
    logic             lk_fault;

    assign sel_idx = lk_valid ? lk_idx : buf_idx;

    page_map_table #(.ENTRIES(ENTRIES)) u_table (
        .clk     (clk),
        .rst     (rst),
        .idx     (sel_idx),
        .rd_entry(old_e),
        .wr_en   (wr_en),
        .wr_entry(wr_e)
    );

    always_comb begin
        kind          = ref_kind_e'(lk_kind);
        is_write_kind = (kind == REF_WMISS) || (kind == REF_DSTORE);
        vac           = is_vacant(old_e);
        bad_par       = !par_good(old_e);
        wp_hit        = is_write_kind && old_e.wp && !vac;
        lk_fault      = vac || wp_hit || bad_par;

        upd_e      = old_e;
        upd_e.refd = 1'b1;
        if (kind == REF_DSTORE) begin
            upd_e.dirty_a = 1'b1;
            upd_e.dirty_b = 1'b1;
        end

        new_e.rpn     = buf_rpn;
        new_e.wp      = buf_wp;
        new_e.dirty_a = buf_dirty;
        new_e.dirty_b = buf_dirty;
        new_e.refd    = 1'b0;
        new_e.par     = make_par(buf_rpn, buf_wp);

        wr_e  = lk_valid ? upd_e : new_e;
        wr_en = lk_valid ? !lk_fault : (commit && !buf_ro);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_is_map   <= 1'b0;
            rsp_rpn      <= '0;
            rsp_wp       <= 1'b0;
            rsp_dirty    <= 1'b0;
            rsp_ref      <= 1'b0;
            rsp_vacant   <= 1'b0;
            rsp_par_err  <= 1'b0;
            rsp_wp_fault <= 1'b0;
            fault_wake   <= 1'b0;
        end else begin
            rsp_valid    <= lk_valid || commit;
            rsp_is_map   <= !lk_valid && commit;
            rsp_rpn      <= old_e.rpn;
            rsp_wp       <= old_e.wp;
            rsp_dirty    <= old_e.dirty_a;
            rsp_ref      <= old_e.refd;
            rsp_vacant   <= vac;
            rsp_par_err  <= bad_par;
            rsp_wp_fault <= lk_valid && wp_hit;
            fault_wake   <= lk_valid && lk_fault;
        end
    end

    assert_map_no_wake_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_is_map |-> !fault_wake);

    assert_wake_from_lookup_R3: assert property (@(posedge clk) disable iff (rst)
        fault_wake |-> (rsp_valid && !rsp_is_map));

    assert_lookup_answers_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (rsp_valid && !rsp_is_map));

    assert_commit_excludes_lookup_R10: assert property (@(posedge clk) disable iff (rst)
        commit |-> !lk_valid);

    assert_wpfault_write_kind_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_wp_fault |-> (rsp_wp && !rsp_vacant && fault_wake));

endmodule

// File: tb/sim_page_map_ctrl.sv
module sim_page_map_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [5:0]  lk_idx;
    logic [1:0]  lk_kind;
    logic        mw_valid;
    logic [5:0]  mw_idx;
    logic [15:0] mw_rpn;
    logic        mw_wp;
    logic        mw_dirty;
    logic        mw_readonly;
    logic        mw_busy;
    logic        mw_proto_err;
    logic        rsp_valid;
    logic        rsp_is_map;
    logic [15:0] rsp_rpn;
    logic        rsp_wp;
    logic        rsp_dirty;
    logic        rsp_ref;
    logic        rsp_vacant;
    logic        rsp_par_err;
    logic        rsp_wp_fault;
    logic        fault_wake;

    int applied = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    page_map_ctrl u0 (.*);

    // {idx[31:26], kind[25:24], old rpn[23:8], 2'b0, wp, dirty, ref, vacant, wpfault, wake}
    localparam logic [31:0] VEC [12] = '{
        {6'd5,  2'd0, 16'h1234, 2'b0, 6'b000000},
        {6'd5,  2'd1, 16'h1234, 2'b0, 6'b001000},
        {6'd5,  2'd2, 16'h1234, 2'b0, 6'b001000},
        {6'd5,  2'd0, 16'h1234, 2'b0, 6'b011000},
        {6'd9,  2'd0, 16'hBEEF, 2'b0, 6'b100000},
        {6'd9,  2'd1, 16'hBEEF, 2'b0, 6'b101011},
        {6'd9,  2'd2, 16'hBEEF, 2'b0, 6'b101011},
        {6'd9,  2'd3, 16'hBEEF, 2'b0, 6'b101000},
        {6'd20, 2'd2, 16'h0F0F, 2'b0, 6'b010000},
        {6'd20, 2'd0, 16'h0F0F, 2'b0, 6'b011000},
        {6'd33, 2'd0, 16'h0000, 2'b0, 6'b110101},
        {6'd33, 2'd2, 16'h0000, 2'b0, 6'b110101}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        applied++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic lookup(input logic [5:0] idx, input logic [1:0] kind, input string req,
                          input logic [15:0] e_rpn, input logic [5:0] e_flags);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_idx   = idx;
        lk_kind  = kind;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "lookup valid/type", {30'd0, rsp_valid, rsp_is_map}, 32'h2);
        chk(req, "lookup old rpn", {16'd0, rsp_rpn}, {16'd0, e_rpn});
        chk(req, "lookup flags", {26'd0, rsp_wp, rsp_dirty, rsp_ref, rsp_vacant,
            rsp_wp_fault, fault_wake}, {26'd0, e_flags});
        chk("R11", "lookup parity", {31'd0, rsp_par_err}, 32'd0);
    endtask

    task automatic mapwr(input logic [5:0] idx, input logic [15:0] rpn, input logic wp,
                         input logic d, input logic ro, input string req,
                         input logic [15:0] e_rpn, input logic [3:0] e_flags);
        logic stayed;
        @(negedge clk);
        mw_valid    = 1'b1;
        mw_idx      = idx;
        mw_rpn      = rpn;
        mw_wp       = wp;
        mw_dirty    = d;
        mw_readonly = ro;
        @(negedge clk);
        mw_valid = 1'b0;
        chk("R6", "busy after accept", {31'd0, mw_busy}, 32'd1);
        stayed = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (!mw_busy || rsp_valid) stayed = 1'b0;
        end
        chk("R6", "busy held 8 more cycles", {31'd0, stayed}, 32'd1);
        @(negedge clk);
        chk(req, "map rsp busy/valid/type", {29'd0, mw_busy, rsp_valid, rsp_is_map}, 32'h3);
        chk(req, "map rsp old rpn", {16'd0, rsp_rpn}, {16'd0, e_rpn});
        chk(req, "map rsp old flags", {28'd0, rsp_wp, rsp_dirty, rsp_ref, rsp_vacant},
            {28'd0, e_flags});
        chk("R8", "map rsp no wake", {30'd0, fault_wake, rsp_wp_fault}, 32'd0);
    endtask

    task automatic run_vec(input logic [31:0] v);
        lookup(v[31:26], v[25:24], "R2/R3/R4/R5", v[23:8], v[5:0]);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        lk_valid = 1'b0; lk_idx = '0; lk_kind = '0;
        mw_valid = 1'b0; mw_idx = '0; mw_rpn = '0;
        mw_wp = 1'b0; mw_dirty = 1'b0; mw_readonly = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset outputs", {29'd0, mw_busy, mw_proto_err, rsp_valid}, 32'd0);

        // setup: each write replaces a Vacant entry (R1 reset contents)
        mapwr(6'd5,  16'h1234, 1'b0, 1'b0, 1'b0, "R1", 16'h0000, 4'b1101);
        mapwr(6'd9,  16'hBEEF, 1'b1, 1'b0, 1'b0, "R1", 16'h0000, 4'b1101);
        mapwr(6'd20, 16'h0F0F, 1'b0, 1'b1, 1'b0, "R1", 16'h0000, 4'b1101);

        for (int i = 0; i < 12; i++) begin
            run_vec(VEC[i]);
        end

        // R7: read-only map write returns old and changes nothing
        mapwr(6'd5, 16'hAAAA, 1'b1, 1'b1, 1'b1, "R7", 16'h1234, 4'b0110);
        lookup(6'd5, 2'd0, "R7", 16'h1234, 6'b011000);

        // R6: real map write, Ref cleared in new entry
        mapwr(6'd5, 16'h5555, 1'b0, 1'b0, 1'b0, "R6", 16'h1234, 4'b0110);
        lookup(6'd5, 2'd0, "R6", 16'h5555, 6'b000000);

        // R8: map write over a Vacant entry flags vacant, no wake
        mapwr(6'd40, 16'h0001, 1'b0, 1'b0, 1'b0, "R8", 16'h0000, 4'b1101);

        // R9: second command while busy is dropped
        @(negedge clk);
        mw_valid = 1'b1; mw_idx = 6'd41; mw_rpn = 16'h7777;
        mw_wp = 1'b0; mw_dirty = 1'b0; mw_readonly = 1'b0;
        @(negedge clk);
        mw_rpn = 16'h2222; mw_idx = 6'd41;
        @(negedge clk);
        mw_valid = 1'b0;
        chk("R9", "proto err set", {31'd0, mw_proto_err}, 32'd1);
        repeat (10) @(negedge clk);
        chk("R9", "busy cleared", {31'd0, mw_busy}, 32'd0);
        lookup(6'd41, 2'd0, "R9", 16'h7777, 6'b000000);

        // R10: lookups over the commit cycle defer the commit
        @(negedge clk);
        mw_valid = 1'b1; mw_idx = 6'd50; mw_rpn = 16'h0A0A;
        mw_wp = 1'b0; mw_dirty = 1'b0; mw_readonly = 1'b0;
        @(negedge clk);
        mw_valid = 1'b0;
        repeat (8) @(negedge clk);
        lk_valid = 1'b1; lk_idx = 6'd5; lk_kind = 2'd0;
        @(negedge clk);
        chk("R10", "busy under lookup", {29'd0, mw_busy, rsp_valid, rsp_is_map}, 32'h6);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R10", "busy under 2nd lookup", {29'd0, mw_busy, rsp_valid, rsp_is_map}, 32'h6);
        @(negedge clk);
        chk("R10", "deferred commit", {28'd0, mw_busy, rsp_valid, rsp_is_map, rsp_vacant},
            32'h7);
        chk("R8", "deferred commit no wake", {31'd0, fault_wake}, 32'd0);
        lookup(6'd50, 2'd0, "R10", 16'h0A0A, 6'b000000);
        chk("R9", "proto err sticky", {31'd0, mw_proto_err}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule